// File: doc/BRIEF.md
# Watchdog Timer with Register Port

This block is a supervisory down-counter for a processor subsystem. Software enables it and sets a timeout constant through a small register port. From then on software must restart the count regularly with a two-write unlock sequence. If the count runs out, the block raises an interrupt. When software has also armed the reset function, it also sends a one-cycle request to the chip reset controller.

The count moves at one quarter of the clock rate. The enable bits can be set but cannot be cleared by writes, and the timeout constant has a floor of 0xFF. So the shortest reachable timeout is 1024 clocks, and a runaway program cannot switch the watchdog off. Reads are combinational on the selected address. Writes take effect at the clock edge where the write strobe is high.

Top module: `wdog_timer`

## Requirements
- R1: After external reset (`rst_n` low) the mode register reads 0, the constant register reads 0xFF, the count reads 0xFF, and `irq` and `rst_req` are low. This reset also clears the timeout flag.
- R2: Address 0 is the mode register. Bit 0 is the enable bit and bit 1 is the reset-enable bit. A write of 1 to either bit sets it. A write of 0 leaves it unchanged. Only external reset or a watchdog reset (R7) clears them.
- R3: Address 1 is the 32-bit timeout constant. A written value below 0xFF is stored as 0xFF. Any other value is stored unchanged.
- R4: A feed is a write of 0xAA to address 2 followed directly by a write of 0x55 to address 2, with no other write between them. Idle cycles are allowed between the two writes. A completed feed copies the constant into the counter and starts counting. An intervening write to any address cancels the sequence without a reload. Address 2 reads 0.
- R5: Once running, the counter at address 3 (read-only) decrements by one every 4 clocks, with the first decrement 4 clocks after the feed. It does not run before the first valid feed.
- R6: When the count is 0 and a further decrement is due, a timeout occurs. This happens (constant+1)×4 clocks after the feed. The timeout sets the timeout flag (mode bit 2) and the interrupt flag (mode bit 3) and stops the counter. With reset-enable clear, `irq` (interrupt flag AND enable) goes high and `rst_req` stays low.
- R7: A timeout with reset-enable set is a watchdog reset. `rst_req` is high for exactly one cycle, starting at the timeout edge. Enable, reset-enable and the interrupt flag are cleared, the timeout flag is left set, the constant and count return to 0xFF, and the counter stops.
- R8: Writing 0 to mode bit 2 clears the timeout flag, and writing 1 leaves it unchanged. Mode bit 3 ignores writes.
- R9: Mode bits 31:4 ignore writes and read as 0.
- R10: A feed sequence while the enable bit is clear has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | External reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 mode, 1 constant, 2 feed, 3 count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt level: interrupt flag while enabled |
| rst_req | output | 1 | One-cycle chip reset request |

## Verification
A behavioural model in the bench follows every register write, the feed state and the divided count, and it is compared with `rdata`, `irq` and `rst_req` on every clock. The stimulus covers several feed patterns: a feed while disabled, a feed cut by a constant write, a clean feed, and feeds of constants below and above the floor. Together these separate a missing or early reload, a wrong clock division and a broken clamp. Two timeouts, one in interrupt-only mode and one in reset mode, separate the two exit paths. Writes of zeros, ones and reserved bits to the mode register show which bits are sticky, which are writable and which are ignored.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_CONST = 2'd1;
  localparam logic [1:0] A_FEED  = 2'd2;
  localparam logic [1:0] A_COUNT = 2'd3;

  typedef struct packed {
    logic int_f;   // bit 3
    logic to_f;    // bit 2
    logic rst_on;  // bit 1
    logic run_on;  // bit 0
  } mode_t;

  function automatic logic [31:0] floor_const(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

  function automatic logic [31:0] mode_word(input mode_t m);
    return {28'd0, m};
  endfunction
endpackage

// File: rtl/wdog_feed.sv
`timescale 1ns/1ps
module wdog_feed #(
  parameter int          DW   = 32,
  parameter logic [31:0] KEY1 = 32'hAA,
  parameter logic [31:0] KEY2 = 32'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_rst,
  input  logic          wr_any,
  input  logic          wr_feed,
  input  logic [DW-1:0] wdata,
  input  logic          enabled,
  output logic          feed_ok
);
  logic armed_q;

  assign feed_ok = wr_feed && armed_q && enabled && (wdata == KEY2[DW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || wd_rst)
      armed_q <= 1'b0;
    else if (wr_any)
      armed_q <= wr_feed && (wdata == KEY1[DW-1:0]);
  end
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count #(
  parameter int          DW      = 32,
  parameter int          PRE_DIV = 4,
  parameter logic [31:0] RST_VAL = 32'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_rst,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] cnt,
  output logic          tick,
  output logic          uflow
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          run_q;

  assign tick  = run_q && (pre_q == PRE_LAST);
  assign uflow = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || wd_rst) begin
      cnt   <= RST_VAL[DW-1:0];
      run_q <= 1'b0;
      pre_q <= '0;
    end else if (load) begin
      cnt   <= load_val;
      run_q <= 1'b1;
      pre_q <= '0;
    end else if (uflow) begin
      run_q <= 1'b0;
      pre_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt   <= cnt - 1'b1;
    end else if (run_q) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
`timescale 1ns/1ps
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          DW     = 32,
  parameter logic [31:0] MIN_TC = 32'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wd_rst,
  input  logic          wr_mode,
  input  logic          wr_const,
  input  logic [DW-1:0] wdata,
  input  logic          uflow,
  output mode_t         mode,
  output logic [DW-1:0] tconst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode   <= '0;
      tconst <= MIN_TC[DW-1:0];
    end else if (wd_rst) begin
      mode.run_on <= 1'b0;
      mode.rst_on <= 1'b0;
      mode.int_f  <= 1'b0;
      mode.to_f   <= 1'b1;
      tconst      <= MIN_TC[DW-1:0];
    end else begin
      if (wr_mode) begin
        if (wdata[0]) mode.run_on <= 1'b1;
        if (wdata[1]) mode.rst_on <= 1'b1;
        if (!wdata[2]) mode.to_f  <= 1'b0;
      end
      if (uflow) begin
        mode.to_f  <= 1'b1;
        mode.int_f <= 1'b1;
      end
      if (wr_const)
        tconst <= DW'(floor_const(32'(wdata), MIN_TC));
    end
  end
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int          DW      = 32,
  parameter int          PRE_DIV = 4,
  parameter logic [31:0] MIN_TC  = 32'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          rst_req
);
  mode_t         mode_q;
  logic [DW-1:0] tc_w;
  logic [DW-1:0] cnt_w;
  logic          tick_w;
  logic          uf_w;
  logic          feed_w;
  logic          wd_rst_w;
  logic          en_w;
  logic          rsten_w;
  logic          tof_w;
  logic          int_w;
  logic          rst_req_q;

  assign en_w     = mode_q.run_on;
  assign rsten_w  = mode_q.rst_on;
  assign tof_w    = mode_q.to_f;
  assign int_w    = mode_q.int_f;
  assign wd_rst_w = uf_w && rsten_w;

  wdog_ctrl #(.DW(DW), .MIN_TC(MIN_TC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst_w),
    .wr_mode(wr_en && addr == A_MODE),
    .wr_const(wr_en && addr == A_CONST),
    .wdata(wdata), .uflow(uf_w), .mode(mode_q), .tconst(tc_w)
  );

  wdog_feed #(.DW(DW)) u_feed (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst_w),
    .wr_any(wr_en), .wr_feed(wr_en && addr == A_FEED),
    .wdata(wdata), .enabled(en_w), .feed_ok(feed_w)
  );

  wdog_count #(.DW(DW), .PRE_DIV(PRE_DIV), .RST_VAL(MIN_TC)) u_count (
    .clk(clk), .rst_n(rst_n), .wd_rst(wd_rst_w),
    .load(feed_w), .load_val(tc_w),
    .cnt(cnt_w), .tick(tick_w), .uflow(uf_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= wd_rst_w;
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = DW'(mode_word(mode_q));
      A_CONST: rdata = tc_w;
      A_COUNT: rdata = cnt_w;
      default: rdata = '0;
    endcase
  end

  assign irq     = int_w && en_w;
  assign rst_req = rst_req_q;
endmodule

// File: rtl/wdog_sva.sv
`timescale 1ns/1ps
module wdog_sva #(
  parameter int          DW     = 32,
  parameter logic [31:0] MIN_TC = 32'hFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          rst_req,
  input logic          en_w,
  input logic          rsten_w,
  input logic          tof_w,
  input logic          int_w,
  input logic [DW-1:0] tc_w,
  input logic [DW-1:0] cnt_w,
  input logic          tick_w,
  input logic          uf_w,
  input logic          feed_w,
  input logic          wd_rst_w
);
  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_w && !wd_rst_w |=> en_w);
  p_rsten_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsten_w && !wd_rst_w |=> rsten_w);
  p_const_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tc_w >= MIN_TC[DW-1:0]);
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_w && !feed_w && !wd_rst_w |=> $stable(cnt_w));
  p_feed_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    feed_w && !wd_rst_w |=> cnt_w == $past(tc_w));
  p_irq_on_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uf_w && !rsten_w && en_w |=> irq && tof_w);
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_wdreset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_w |=> rst_req && tof_w && !int_w && !en_w && !rsten_w);
endmodule

bind wdog_timer wdog_sva #(.DW(DW), .MIN_TC(MIN_TC)) u_sva (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rst_req(rst_req),
  .en_w(en_w), .rsten_w(rsten_w), .tof_w(tof_w), .int_w(int_w),
  .tc_w(tc_w), .cnt_w(cnt_w), .tick_w(tick_w), .uf_w(uf_w),
  .feed_w(feed_w), .wd_rst_w(wd_rst_w)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;

  int checks = 0, fails = 0, cyc = 0;
  // reference model state
  int     m_en = 0, m_rsten = 0, m_tof = 0, m_int = 0, m_run = 0, m_pre = 0, m_armed = 0, m_rq = 0;
  longint m_tc = 255, m_cnt = 255;

  always #2.5 clk = ~clk;

  wdog_timer i_wdog_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin : ref_model
    int     uf, fed;
    longint d;
    cyc++;
    d  = longint'(wdata);
    uf = (m_run != 0 && m_pre == 3 && m_cnt == 0) ? 1 : 0;
    if (!rst_n) begin
      m_en = 0; m_rsten = 0; m_tof = 0; m_int = 0; m_run = 0; m_pre = 0;
      m_armed = 0; m_rq = 0; m_tc = 255; m_cnt = 255;
    end else if (uf != 0 && m_rsten != 0) begin
      m_rq = 1;
      m_en = 0; m_rsten = 0; m_int = 0; m_tof = 1; m_run = 0; m_pre = 0;
      m_armed = 0; m_tc = 255; m_cnt = 255;
    end else begin
      m_rq = 0;
      if (uf != 0) begin m_run = 0; m_pre = 0; end
      else if (m_run != 0) begin
        if (m_pre == 3) begin m_pre = 0; m_cnt = m_cnt - 1; end
        else m_pre = m_pre + 1;
      end
      fed = (wr_en && addr == 2 && d == 'h55 && m_armed != 0 && m_en != 0) ? 1 : 0;
      if (wr_en) m_armed = (addr == 2 && d == 'hAA) ? 1 : 0;
      if (fed != 0) begin m_cnt = m_tc; m_run = 1; m_pre = 0; end
      if (wr_en && addr == 0) begin
        if (wdata[0]) m_en = 1;
        if (wdata[1]) m_rsten = 1;
        if (!wdata[2]) m_tof = 0;
      end
      if (wr_en && addr == 1) m_tc = (d < 255) ? 255 : d;
      if (uf != 0) begin m_tof = 1; m_int = 1; end
    end
  end

  // compare against the model on every clock, away from the edge
  always @(posedge clk) begin : compare
    longint exp_rd;
    #1;
    if (rst_n) begin
      check("R6 irq vs model", longint'(irq), (m_int != 0 && m_en != 0) ? 1 : 0);
      check("R7 rst_req vs model", longint'(rst_req), longint'(m_rq));
      case (addr)
        2'd0: exp_rd = longint'(m_en + 2*m_rsten + 4*m_tof + 8*m_int);
        2'd1: exp_rd = m_tc;
        2'd3: exp_rd = m_cnt;
        default: exp_rd = 0;
      endcase
      case (addr)
        2'd0: check("R2 mode vs model", longint'(rdata), exp_rd);
        2'd1: check("R3 const vs model", longint'(rdata), exp_rd);
        2'd2: check("R4 feed reads 0", longint'(rdata), exp_rd);
        default: check("R5 count vs model", longint'(rdata), exp_rd);
      endcase
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output longint v);
    @(negedge clk); addr = a; #1; v = longint'(rdata);
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
  endtask

  initial begin : watchdog
    #600000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    longint v;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, v); check("R1 mode after reset", v, 0);
    rd(2'd1, v); check("R1 const after reset", v, 'hFF);
    rd(2'd3, v); check("R1 count after reset", v, 'hFF);
    check("R1 irq after reset", longint'(irq), 0);
    check("R1 rst_req after reset", longint'(rst_req), 0);
    // R3 clamp
    wr(2'd1, 32'h5);   rd(2'd1, v); check("R3 small const clamped", v, 'hFF);
    wr(2'd1, 32'h300); rd(2'd1, v); check("R3 large const kept", v, 'h300);
    // R10 feed while disabled
    feed(); repeat (8) @(negedge clk);
    rd(2'd3, v); check("R10 disabled feed ignored", v, 'hFF);
    // enable
    wr(2'd0, 32'h1); rd(2'd0, v); check("R2 enable set", v, 1);
    // R4 aborted feed
    wr(2'd2, 32'hAA); wr(2'd1, 32'h300); wr(2'd2, 32'h55);
    repeat (8) @(negedge clk);
    rd(2'd3, v); check("R4 aborted feed no reload", v, 'hFF);
    // R4/R5 proper feed, then 40 clocks = 10 decrements
    feed(); addr = 2'd3;
    repeat (40) @(negedge clk);
    #1; check("R5 count after 40 clocks", longint'(rdata), 'h300 - 10);
    // R6 interrupt-only timeout
    wr(2'd1, 32'h100); feed();
    repeat (1100) @(negedge clk);
    #1;
    check("R6 irq after timeout", longint'(irq), 1);
    check("R6 no rst_req", longint'(rst_req), 0);
    rd(2'd0, v); check("R6 flags set", v, 'hD);
    rd(2'd3, v); check("R6 counter stopped at 0", v, 0);
    // R8 clear timeout flag, bit 3 read-only
    wr(2'd0, 32'h9); rd(2'd0, v); check("R8 tof cleared, int kept", v, 'h9);
    // R9 reserved bits ignored
    wr(2'd0, 32'hFFFF_FFF4); rd(2'd0, v); check("R9 reserved ignored", v, 'h9);
    // R2 zero write keeps enables
    wr(2'd0, 32'h0); rd(2'd0, v); check("R2 enable sticky", v, 'h9);
    // R7 reset mode timeout
    wr(2'd0, 32'h2); rd(2'd0, v); check("R2 reset-enable set", v, 'hB);
    feed();
    seen = 0;
    for (int i = 1; i <= 1200; i++) begin
      @(negedge clk);
      if (rst_req && seen == 0) seen = i;
      if (seen != 0) break;
    end
    check("R7 rst_req timing after feed", longint'(seen), 1028);
    @(negedge clk); check("R7 rst_req single cycle", longint'(rst_req), 0);
    rd(2'd0, v); check("R7 mode after watchdog reset", v, 'h4);
    rd(2'd1, v); check("R7 const restored", v, 'hFF);
    rd(2'd3, v); check("R7 count restored", v, 'hFF);
    check("R7 irq low", longint'(irq), 0);
    // R1 external reset clears timeout flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, v); check("R1 external reset clears tof", v, 0);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule